// File: doc/BRIEF.md
# Thermal Sensor Power and Conversion Sequencer

This block drives an on-chip analog temperature sensing core through a three-bit control word. Its inputs are single-cycle requests to enable the core, to disable it, and to take one reading. It turns these into the control patterns the core needs, in a fixed order and with minimum gaps measured in clock cycles. When the core is powered down, the reset line is held low. Before reset is released, the core spends a power-up interval with every control bit at zero. Each reading is started by a run pulse of fixed width.

After the run pulse, the block waits for the core's single-cycle completion signal. It captures the 12-bit raw reading from the core's output word and reports the outcome on a one-cycle status strobe with a code. The wait is bounded by a timeout. A request made while the core is off is answered at once with a no-data code. Every delay is a parameter derived from the clock frequency, so a simulation can use short values. Temperature scaling and bus access belong to the surrounding logic.

Top module: `thsq_seq`

## Requirements
- R1: A synchronous reset puts the block in the off state: `ctl_word` = 3'b010 (bit 0 active-low core reset = 0, bit 1 power-down = 1, bit 2 run = 0), and `enabled`, `busy`, `res_valid` and `stat_valid` are all 0.
- R2: The enable sequence runs in three timed phases. After an enable request in the off state, `ctl_word` stays 3'b010 for PDH_CYC cycles, then goes to 3'b000 for PU_CYC cycles, then to 3'b001 for SU_CYC cycles with `busy` high. After that, `busy` falls while `ctl_word` stays 3'b001.
- R3: The core reset bit (bit 0) is 0 whenever power-down (bit 1) is 1. Bit 0 rises only after at least PU_CYC consecutive cycles of 3'b000.
- R4: A conversion request while enabled and not busy drives `ctl_word` = 3'b101 for exactly RUN_CYC cycles. Then `ctl_word` returns to 3'b001 and `busy` stays high while the block waits.
- R5: A done pulse in any of the first TMO_CYC cycles after the run bit clears is accepted. One cycle later, `stat_valid` pulses with `stat_code` = 0 (OK), `res_valid` is 1, `result` equals bits 27:16 of `sense_word` in the done cycle, and `busy` is 0. `res_valid` clears when the next conversion starts.
- R6: If no done pulse arrives in that window, `stat_valid` pulses with `stat_code` = 2 (timeout) on the TMO_CYC-th cycle after the run bit clears. `res_valid` stays 0, and a later done pulse is ignored.
- R7: A conversion request while off gives `stat_valid` with `stat_code` = 1 (no data) in the next cycle. `ctl_word` stays 3'b010.
- R8: A conversion request while `busy` is high (during power-up, run or wait) is ignored. The phase lengths stay unchanged and no extra status is produced.
- R9: An enable request while enabled, or a disable request while off, has no effect on `ctl_word`, `busy` or the status outputs.
- R10: A disable request in any enabled state gives `ctl_word` = 3'b010 and `enabled` = 0 in the next cycle. This aborts any conversion in progress without a status pulse, even if a done pulse arrives in the same cycle.
- R11: The run bit is 1 only while the core reset bit is 1 and power-down is 0.
- R12: `stat_valid` is a one-cycle strobe, and at most one outcome is reported per cycle, with codes 0 = OK, 1 = no data and 2 = timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| conv_req | input | 1 | Single conversion request pulse |
| core_done | input | 1 | Conversion complete pulse from the core |
| sense_word | input | 32 | Core output word, raw reading in bits 27:16 |
| ctl_word | output | 3 | Core control: bit 0 reset_n, bit 1 power-down, bit 2 run |
| enabled | output | 1 | Core is on or powering up |
| busy | output | 1 | Powering up or a conversion is in flight |
| result | output | 12 | Last captured raw reading |
| res_valid | output | 1 | `result` holds the reading of the last conversion |
| stat_valid | output | 1 | Outcome strobe |
| stat_code | output | 2 | Outcome: 0 OK, 1 no data, 2 timeout |

## Verification
The assertions check, on every cycle, the control-word invariants: run only with reset released and power on, and reset held while powered down. They also check that the power-up window is never cut short, that a run only starts from an accepted request, that at most one outcome is reported per cycle, and that disable and off-state requests produce the right next-cycle response. Only the bench scenarios can show the exact phase lengths, the boundary of the done window at TMO_CYC-1 versus TMO_CYC, the extraction of bits 27:16, requests that are ignored while busy, and an abort where disable and done arrive together.

// File: rtl/thsq_pkg.sv
package thsq_pkg;

  typedef enum logic [2:0] {
    S_OFF, S_PDHOLD, S_PWRUP, S_SETUP, S_IDLE, S_RUN, S_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_NODATA  = 2'd1,
    ST_TIMEOUT = 2'd2
  } stat_t;

  // control word bit positions, decoded by the analog core
  localparam int CTL_RSTN = 0;
  localparam int CTL_PD   = 1;
  localparam int CTL_RUN  = 2;

  localparam int RAW_LSB = 16;
  localparam int RAW_W   = 12;

  // control pattern presented in each state
  function automatic logic [2:0] ctl_of(seq_state_t s);
    logic [2:0] c;
    c = '0;
    case (s)
      S_OFF, S_PDHOLD: c[CTL_PD] = 1'b1;
      S_PWRUP:         c = '0;
      S_RUN:           begin c[CTL_RSTN] = 1'b1; c[CTL_RUN] = 1'b1; end
      default:         c[CTL_RSTN] = 1'b1;
    endcase
    return c;
  endfunction

  function automatic logic [RAW_W-1:0] raw_of(logic [31:0] w);
    return w[RAW_LSB +: RAW_W];
  endfunction

  // cycles covering a duration in ns at a clock in MHz, at least one
  function automatic int cyc_of_ns(int mhz, int ns);
    longint t;
    t = (longint'(mhz) * longint'(ns) + 999) / 1000;
    if (t < 1) t = 1;
    return int'(t);
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/thsq_delay.sv
module thsq_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/thsq_fsm.sv
module thsq_fsm
  import thsq_pkg::*;
#(
  parameter int PDH_CYC = 4,
  parameter int PU_CYC  = 16,
  parameter int SU_CYC  = 4,
  parameter int RUN_CYC = 4,
  parameter int TMO_CYC = 32,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic             conv_req,
  input  logic             core_done,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output seq_state_t       state,
  output logic             ev_start,
  output logic             ev_ok,
  output logic             ev_nodata,
  output logic             ev_tmo
);
  localparam logic [CNT_W-1:0] LD_PDH = CNT_W'(PDH_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PU  = CNT_W'(PU_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SU  = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RUN = CNT_W'(RUN_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TMO = CNT_W'(TMO_CYC - 1);

  seq_state_t nxt;

  always_comb begin
    nxt       = state;
    load      = 1'b0;
    load_val  = '0;
    ev_start  = 1'b0;
    ev_ok     = 1'b0;
    ev_nodata = 1'b0;
    ev_tmo    = 1'b0;
    if (state == S_OFF) begin
      if (conv_req) ev_nodata = 1'b1;
      if (en_req) begin
        nxt = S_PDHOLD; load = 1'b1; load_val = LD_PDH;
      end
    end else if (dis_req) begin
      nxt = S_OFF;
    end else begin
      case (state)
        S_PDHOLD: if (expired) begin nxt = S_PWRUP; load = 1'b1; load_val = LD_PU; end
        S_PWRUP:  if (expired) begin nxt = S_SETUP; load = 1'b1; load_val = LD_SU; end
        S_SETUP:  if (expired) nxt = S_IDLE;
        S_IDLE:   if (conv_req) begin
                    nxt = S_RUN; load = 1'b1; load_val = LD_RUN; ev_start = 1'b1;
                  end
        S_RUN:    if (expired) begin nxt = S_WAIT; load = 1'b1; load_val = LD_TMO; end
        S_WAIT:   if (core_done) begin
                    nxt = S_IDLE; ev_ok = 1'b1;
                  end else if (expired) begin
                    nxt = S_IDLE; ev_tmo = 1'b1;
                  end
        default:  nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_OFF;
    else     state <= nxt;
  end
endmodule

// File: rtl/thsq_result.sv
module thsq_result
  import thsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_start,
  input  logic             ev_ok,
  input  logic             ev_nodata,
  input  logic             ev_tmo,
  input  logic [31:0]      sense_word,
  output logic [RAW_W-1:0] result,
  output logic             res_valid,
  output logic             stat_valid,
  output logic [1:0]       stat_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      res_valid  <= 1'b0;
      stat_valid <= 1'b0;
      stat_code  <= ST_OK;
    end else begin
      stat_valid <= ev_ok | ev_nodata | ev_tmo;
      if (ev_ok)          stat_code <= ST_OK;
      else if (ev_nodata) stat_code <= ST_NODATA;
      else if (ev_tmo)    stat_code <= ST_TIMEOUT;
      if (ev_start) res_valid <= 1'b0;
      if (ev_ok) begin
        result    <= raw_of(sense_word);
        res_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/thsq_seq.sv
module thsq_seq
  import thsq_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int PDH_CYC = cyc_of_ns(CLK_MHZ, 1000),
  parameter int PU_CYC  = cyc_of_ns(CLK_MHZ, 60000),
  parameter int SU_CYC  = cyc_of_ns(CLK_MHZ, 1000),
  parameter int RUN_CYC = cyc_of_ns(CLK_MHZ, 1000),
  parameter int TMO_CYC = cyc_of_ns(CLK_MHZ, 10000000)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en_req,
  input  logic        dis_req,
  input  logic        conv_req,
  input  logic        core_done,
  input  logic [31:0] sense_word,
  output logic [2:0]  ctl_word,
  output logic        enabled,
  output logic        busy,
  output logic [11:0] result,
  output logic        res_valid,
  output logic        stat_valid,
  output logic [1:0]  stat_code
);
  localparam int MAX_CYC = max_of(max_of(max_of(PDH_CYC, PU_CYC), max_of(SU_CYC, RUN_CYC)), TMO_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  seq_state_t       state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             ev_start, ev_ok, ev_nodata, ev_tmo;

  thsq_delay #(.CNT_W(CNT_W)) i_delay (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  thsq_fsm #(
    .PDH_CYC(PDH_CYC), .PU_CYC(PU_CYC), .SU_CYC(SU_CYC),
    .RUN_CYC(RUN_CYC), .TMO_CYC(TMO_CYC), .CNT_W(CNT_W)
  ) i_fsm (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .conv_req(conv_req),
    .core_done(core_done), .expired(tmr_expired), .load(tmr_load), .load_val(tmr_val),
    .state(state), .ev_start(ev_start), .ev_ok(ev_ok), .ev_nodata(ev_nodata), .ev_tmo(ev_tmo)
  );

  thsq_result i_result (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_ok(ev_ok), .ev_nodata(ev_nodata),
    .ev_tmo(ev_tmo), .sense_word(sense_word), .result(result), .res_valid(res_valid),
    .stat_valid(stat_valid), .stat_code(stat_code)
  );

  assign ctl_word = ctl_of(state);
  assign enabled  = (state != S_OFF);
  assign busy     = (state != S_OFF) && (state != S_IDLE);
endmodule

// File: rtl/thsq_chk.sv
module thsq_chk #(
  parameter int PU_CYC = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] ctl_word,
  input logic       enabled,
  input logic       busy,
  input logic       conv_req,
  input logic       dis_req,
  input logic       res_valid,
  input logic       stat_valid,
  input logic [1:0] stat_code,
  input logic       ev_ok,
  input logic       ev_nodata,
  input logic       ev_tmo
);
  int pu_cnt;

  always_ff @(posedge clk) begin
    if (rst)                    pu_cnt <= 0;
    else if (ctl_word == 3'b000) begin
      if (pu_cnt < PU_CYC)      pu_cnt <= pu_cnt + 1;
    end else                    pu_cnt <= 0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ctl_word == 3'b010) && !enabled && !stat_valid && !res_valid);

  // R3
  pd_holds_rst_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_word[1] |-> !ctl_word[0]);

  // R3
  pu_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_word[0]) |-> (pu_cnt >= PU_CYC));

  // R11
  run_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_word[2] |-> (ctl_word[0] && !ctl_word[1]));

  // R8
  run_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_word[2]) |-> ($past(conv_req) && !$past(busy)));

  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_ok, ev_nodata, ev_tmo}));

  // R7
  nodata_chk: assert property (@(posedge clk) disable iff (rst)
    (!enabled && conv_req) |=> (stat_valid && stat_code == 2'd1));

  // R10
  dis_off_chk: assert property (@(posedge clk) disable iff (rst)
    (enabled && dis_req) |=> ((ctl_word == 3'b010) && !enabled && !stat_valid));

  // R5
  ok_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ev_ok |=> (res_valid && stat_valid && stat_code == 2'd0));
endmodule

bind thsq_seq thsq_chk #(.PU_CYC(PU_CYC)) i_chk (
  .clk(clk), .rst(rst), .ctl_word(ctl_word), .enabled(enabled), .busy(busy),
  .conv_req(conv_req), .dis_req(dis_req), .res_valid(res_valid),
  .stat_valid(stat_valid), .stat_code(stat_code),
  .ev_ok(ev_ok), .ev_nodata(ev_nodata), .ev_tmo(ev_tmo)
);

// File: tb/test_thsq_seq.sv
module test_thsq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PDH = 3;
  localparam int PU  = 20;
  localparam int SU  = 4;
  localparam int RUN = 5;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_req = 1'b0, dis_req = 1'b0, conv_req = 1'b0, core_done = 1'b0;
  logic [31:0] sense_word = '0;
  logic [2:0]  ctl_word;
  logic        enabled, busy, res_valid, stat_valid;
  logic [11:0] result;
  logic [1:0]  stat_code;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thsq_seq #(.PDH_CYC(PDH), .PU_CYC(PU), .SU_CYC(SU), .RUN_CYC(RUN), .TMO_CYC(TMO)) i_thsq_seq (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .conv_req(conv_req),
    .core_done(core_done), .sense_word(sense_word), .ctl_word(ctl_word), .enabled(enabled),
    .busy(busy), .result(result), .res_valid(res_valid), .stat_valid(stat_valid),
    .stat_code(stat_code)
  );

  function automatic int exp_raw(logic [31:0] w);
    return int'((w / 32'd65536) % 32'd4096);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // enable and measure the three phases; poke adds a request during power-up
  task automatic do_enable(bit poke);
    int n, nstat;
    nstat = 0;
    en_req = 1'b1; @(negedge clk); en_req = 1'b0;
    n = 0;
    while (ctl_word == 3'b010 && n < 1000) begin n++; @(negedge clk); end
    chk(n == PDH, "R2", "pd hold cycles", n, PDH);
    n = 0;
    while (ctl_word == 3'b000 && n < 1000) begin
      n++;
      conv_req = (poke && n == 3);
      if (stat_valid) nstat++;
      @(negedge clk);
    end
    conv_req = 1'b0;
    chk(n == PU, "R3", "power-up cycles", n, PU);
    n = 0;
    while (ctl_word == 3'b001 && busy && n < 1000) begin
      n++;
      if (stat_valid) nstat++;
      @(negedge clk);
    end
    chk(n == SU, "R2", "setup cycles", n, SU);
    chk(ctl_word == 3'b001 && !busy && enabled, "R2", "ready ctl", int'(ctl_word), 1);
    if (poke) chk(nstat == 0, "R8", "status during power-up", nstat, 0);
  endtask

  task automatic do_conv(int lat, logic [31:0] word, bit poke);
    int n, seen, scode;
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    chk(ctl_word == 3'b101 && busy, "R4", "run ctl", int'(ctl_word), 5);
    chk(!res_valid, "R5", "res_valid cleared at start", int'(res_valid), 0);
    n = 0;
    while (ctl_word == 3'b101 && n < 100) begin
      n++;
      conv_req = (poke && n == 2);
      @(negedge clk);
    end
    conv_req = 1'b0;
    chk(n == RUN, poke ? "R8" : "R4", "run width", n, RUN);
    chk(ctl_word == 3'b001 && busy, "R4", "wait ctl", int'(ctl_word), 1);
    seen = -1; scode = 0;
    for (int k = 1; k <= lat; k++) begin
      sense_word = $urandom;
      @(negedge clk);
      if (stat_valid && seen < 0) begin seen = k; scode = int'(stat_code); end
    end
    if (lat < TMO) begin
      chk(seen < 0, "R5", "no early status", seen, -1);
      core_done = 1'b1; sense_word = word;
      @(negedge clk);
      core_done = 1'b0;
      chk(stat_valid && stat_code == 2'd0, "R5", "ok status", int'(stat_code), 0);
      chk(res_valid && int'(result) == exp_raw(word), "R5", "result", int'(result), exp_raw(word));
      chk(!busy && ctl_word == 3'b001, "R5", "idle after done", int'(busy), 0);
      @(negedge clk);
      chk(!stat_valid, "R12", "one-cycle strobe", int'(stat_valid), 0);
    end else begin
      chk(seen == TMO && scode == 2, "R6", "timeout cycle", seen, TMO);
      core_done = 1'b1; sense_word = word;
      @(negedge clk);
      core_done = 1'b0;
      chk(!stat_valid && !res_valid && !busy, "R6", "late done ignored", int'(stat_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl_word == 3'b010, "R1", "reset ctl", int'(ctl_word), 2);
    chk(!enabled && !busy && !res_valid && !stat_valid, "R1", "reset flags", int'(enabled), 0);
    rst = 1'b0;
    @(negedge clk);

    // R9 disable while off
    dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
    chk(ctl_word == 3'b010 && !enabled && !stat_valid, "R9", "disable while off", int'(ctl_word), 2);

    // R7 conversion while off
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    chk(stat_valid && stat_code == 2'd1, "R7", "nodata status", int'(stat_code), 1);
    chk(ctl_word == 3'b010, "R7", "no strobes", int'(ctl_word), 2);
    @(negedge clk);

    do_enable(1'b1);

    // R9 enable while enabled
    en_req = 1'b1; @(negedge clk); en_req = 1'b0;
    chk(ctl_word == 3'b001 && !busy && !stat_valid, "R9", "enable while on", int'(ctl_word), 1);

    do_conv(0, 32'hA5A3_C7E1, 1'b0);
    do_conv(TMO - 1, 32'h0FFF_0000, 1'b0);
    do_conv(TMO, 32'h0123_4567, 1'b0);
    do_conv(3, 32'hF000_FFFF, 1'b1);

    for (int i = 0; i < 25; i++) begin
      do_conv(int'($urandom_range(0, TMO - 1)), $urandom, bit'($urandom_range(0, 1)));
    end

    // R10 disable during wait, with done in the same cycle
    conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
    repeat (RUN + 2) @(negedge clk);
    dis_req = 1'b1; core_done = 1'b1; sense_word = 32'h0ABC_0000;
    @(negedge clk);
    dis_req = 1'b0; core_done = 1'b0;
    chk(ctl_word == 3'b010 && !enabled, "R10", "disable ctl", int'(ctl_word), 2);
    chk(!stat_valid && !res_valid, "R10", "abort without status", int'(stat_valid), 0);
    @(negedge clk);

    do_enable(1'b0);
    do_conv(7, 32'h0765_4321, 1'b0);

    // R1 reset during power-up
    en_req = 1'b1; @(negedge clk); en_req = 1'b0;
    dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
    do_enable(1'b0);
    rst = 1'b1; @(negedge clk);
    chk(ctl_word == 3'b010 && !enabled && !res_valid, "R1", "reset when on", int'(ctl_word), 2);
    rst = 1'b0;
    en_req = 1'b1; @(negedge clk); en_req = 1'b0;
    repeat (PDH + 5) @(negedge clk);
    rst = 1'b1; @(negedge clk);
    chk(ctl_word == 3'b010 && !busy, "R1", "reset mid power-up", int'(ctl_word), 2);
    rst = 1'b0;
    @(negedge clk);

    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule